// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps the state of 256 interrupt vectors in three bit arrays: request, in-service and enable. Interrupt sources raise a vector by number. The block keeps the request only when that vector is enabled. The core sees a pending flag and the vector that would be delivered next. A higher vector number has higher priority. A request is offered only when it ranks above everything currently in service, so nested handlers are never pre-empted by equal or lower work.

When the core takes an interrupt it acknowledges the vector. That moves the vector from request to in-service in one step. An end-of-interrupt retires whichever in-service vector ranks highest; the caller does not name it. An end-of-interrupt that arrives with nothing in service is reported on a one-cycle spurious flag. A register bank reads any 32-bit slice of the arrays through a combinational port, and it rewrites the enable array one slice at a time.

Top module: `vit_tracker`

## Requirements
- R1: After reset the request and in-service arrays are all zero, every enable bit is one, the trigger-mode view reads zero, and `pend_valid` and `spurious_eoi` are low.
- R2: A raise of vector v whose enable bit is one sets request bit v at the next clock edge. Slice k of any array holds vectors 32k to 32k+31, and bit v%32 of that slice is vector v.
- R3: A raise of a vector whose enable bit is zero is dropped, and the request array is left unchanged.
- R4: While `pend_valid` is high, `pend_vec` is the highest-numbered set request bit.
- R5: `pend_valid` is high only when some request bit is set and the highest request vector is strictly greater than the highest in-service vector. An empty in-service array ranks below vector 0. `pend_vec` reads 0 when `pend_valid` is low.
- R6: An acknowledge of vector v sets in-service bit v and clears request bit v at the same clock edge.
- R7: An end-of-interrupt clears only the highest set in-service bit.
- R8: An end-of-interrupt with the in-service array empty changes no state, and it raises `spurious_eoi` for exactly the following cycle.
- R9: An enable write replaces slice `en_wr_idx` of the enable array with `en_wr_data`. The read port returns slice `rd_idx` of the array chosen by `rd_sel`: 0 is request, 1 is in-service, 2 is enable, and 3 is trigger mode, which always reads zero.
- R10: Operations that arrive in the same cycle are all applied. The end-of-interrupt picks its victim from the in-service state before that cycle's acknowledge. A raise and an acknowledge of the same vector leave its request bit clear. A raise is judged against the enable state before that cycle's enable write.
- R11: State changes at the clock edge after an operation, and `pend_valid`, `pend_vec` and `rd_data` follow the new state within that same cycle, with no further latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_valid | input | 1 | Raise request strobe |
| raise_vec | input | 8 | Vector being raised |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_vec | input | 8 | Vector being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| en_wr_valid | input | 1 | Enable slice write strobe |
| en_wr_idx | input | 3 | Enable slice index |
| en_wr_data | input | 32 | New enable slice contents |
| rd_sel | input | 2 | Array chosen for reading |
| rd_idx | input | 3 | Slice index for reading |
| rd_data | output | 32 | Selected slice |
| pend_valid | output | 1 | A deliverable interrupt exists |
| pend_vec | output | 8 | Vector to deliver |
| spurious_eoi | output | 1 | End-of-interrupt arrived with nothing in service |

## Verification
A corrupted request or in-service bit appears at the ports in the cycle after it is written. It shows up as a wrong `pend_vec`, as `pend_valid` asserting under a handler it should not pre-empt, or as a wrong value in a read slice, because all three outputs are combinational views of the arrays. A wrong end-of-interrupt victim stays hidden until the next retirement, or until a lower request that should be masked becomes pending. For that reason the bench reads back every slice of every array after each operation. It also drives the core through nesting, masking and same-cycle collisions, which make such faults visible at the next edge.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int VIT_NUM_VEC = 256;
  localparam int VIT_GROUP   = 8;
  localparam int VIT_SLICE_W = 32;

  typedef enum logic [1:0] {
    RD_REQ  = 2'd0,
    RD_SVC  = 2'd1,
    RD_EN   = 2'd2,
    RD_TRIG = 2'd3
  } vit_rd_sel_e;
endpackage

// File: rtl/vit_prio_enc.sv
// Two-level highest-set-bit finder: per-group local winner, then highest group.
module vit_prio_enc #(
  parameter int N = 256,
  parameter int G = 8
) (
  input  logic [N-1:0]         bits_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int NG = N / G;
  localparam int LW = $clog2(G);
  localparam int GW = $clog2(NG);

  logic [NG-1:0]         grp_any;
  logic [NG-1:0][LW-1:0] grp_idx;
  logic [GW-1:0]         hi_grp;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [LW-1:0] loc;
    always_comb begin
      loc = '0;
      for (int b = 0; b < G; b++) begin
        if (bits_i[g*G + b]) loc = LW'(b);
      end
    end
    assign grp_idx[g] = loc;
    assign grp_any[g] = |bits_i[g*G +: G];
  end

  always_comb begin
    hi_grp = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp_any[g]) hi_grp = GW'(g);
    end
  end

  assign any_o = |grp_any;
  assign idx_o = {hi_grp, grp_idx[hi_grp]};
endmodule

// File: rtl/vit_slice_rd.sv
module vit_slice_rd
  import vit_pkg::*;
#(
  parameter int N = 256,
  parameter int W = 32
) (
  input  logic [N-1:0]               req_i,
  input  logic [N-1:0]               svc_i,
  input  logic [N-1:0]               en_i,
  input  logic [1:0]                 sel_i,
  input  logic [$clog2(N/W)-1:0]     idx_i,
  output logic [W-1:0]               data_o
);
  always_comb begin
    case (vit_rd_sel_e'(sel_i))
      RD_REQ:  data_o = req_i[idx_i*W +: W];
      RD_SVC:  data_o = svc_i[idx_i*W +: W];
      RD_EN:   data_o = en_i[idx_i*W +: W];
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/vit_tracker.sv
module vit_tracker
  import vit_pkg::*;
#(
  parameter int NUM_VEC = VIT_NUM_VEC,
  parameter int GROUP   = VIT_GROUP,
  parameter int SLICE_W = VIT_SLICE_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 raise_valid,
  input  logic [$clog2(NUM_VEC)-1:0]           raise_vec,
  input  logic                                 ack_valid,
  input  logic [$clog2(NUM_VEC)-1:0]           ack_vec,
  input  logic                                 eoi_valid,
  input  logic                                 en_wr_valid,
  input  logic [$clog2(NUM_VEC/SLICE_W)-1:0]   en_wr_idx,
  input  logic [SLICE_W-1:0]                   en_wr_data,
  input  logic [1:0]                           rd_sel,
  input  logic [$clog2(NUM_VEC/SLICE_W)-1:0]   rd_idx,
  output logic [SLICE_W-1:0]                   rd_data,
  output logic                                 pend_valid,
  output logic [$clog2(NUM_VEC)-1:0]           pend_vec,
  output logic                                 spurious_eoi
);
  localparam int VW = $clog2(NUM_VEC);
  localparam logic [NUM_VEC-1:0] ONE_HOT0 = {{(NUM_VEC-1){1'b0}}, 1'b1};

  logic [NUM_VEC-1:0] req_q, svc_q, en_q;
  logic [NUM_VEC-1:0] req_nx, svc_nx, en_nx;
  logic [NUM_VEC-1:0] raise_oh, ack_oh, eoi_oh;
  logic               spur_q, spur_nx, upd;
  logic               req_any, svc_any;
  logic [VW-1:0]      req_hi, svc_hi;

  vit_prio_enc #(.N(NUM_VEC), .G(GROUP)) i_req_enc (
    .bits_i(req_q), .any_o(req_any), .idx_o(req_hi)
  );

  vit_prio_enc #(.N(NUM_VEC), .G(GROUP)) i_svc_enc (
    .bits_i(svc_q), .any_o(svc_any), .idx_o(svc_hi)
  );

  vit_slice_rd #(.N(NUM_VEC), .W(SLICE_W)) i_rd (
    .req_i(req_q), .svc_i(svc_q), .en_i(en_q),
    .sel_i(rd_sel), .idx_i(rd_idx), .data_o(rd_data)
  );

  // Next-state logic
  always_comb begin
    upd      = raise_valid | ack_valid | eoi_valid | en_wr_valid;
    raise_oh = (raise_valid && en_q[raise_vec]) ? (ONE_HOT0 << raise_vec) : '0;
    ack_oh   = ack_valid ? (ONE_HOT0 << ack_vec) : '0;
    eoi_oh   = (eoi_valid && svc_any) ? (ONE_HOT0 << svc_hi) : '0;
    req_nx   = (req_q | raise_oh) & ~ack_oh;
    svc_nx   = (svc_q & ~eoi_oh) | ack_oh;
    en_nx    = en_q;
    if (en_wr_valid) en_nx[en_wr_idx*SLICE_W +: SLICE_W] = en_wr_data;
    spur_nx  = eoi_valid && !svc_any;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      svc_q  <= '0;
      en_q   <= '1;
      spur_q <= 1'b0;
    end else begin
      if (upd) begin
        req_q <= req_nx;
        svc_q <= svc_nx;
        en_q  <= en_nx;
      end
      spur_q <= spur_nx;
    end
  end

  assign pend_valid   = req_any && (!svc_any || (req_hi > svc_hi));
  assign pend_vec     = pend_valid ? req_hi : '0;
  assign spurious_eoi = spur_q;
endmodule

// File: rtl/vit_tracker_chk.sv
module vit_tracker_chk #(
  parameter int NUM_VEC = 256
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       raise_valid,
  input logic [$clog2(NUM_VEC)-1:0] raise_vec,
  input logic                       ack_valid,
  input logic [$clog2(NUM_VEC)-1:0] ack_vec,
  input logic                       eoi_valid,
  input logic                       pend_valid,
  input logic [$clog2(NUM_VEC)-1:0] pend_vec,
  input logic                       spurious_eoi,
  input logic [NUM_VEC-1:0]         req_q,
  input logic [NUM_VEC-1:0]         svc_q,
  input logic [NUM_VEC-1:0]         en_q
);
  localparam logic [NUM_VEC-1:0] ONE_V = {{(NUM_VEC-1){1'b0}}, 1'b1};

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (req_q == '0 && svc_q == '0 && (&en_q) && !spurious_eoi));

  p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_valid && en_q[raise_vec] && !(ack_valid && ack_vec == raise_vec))
      |=> req_q[$past(raise_vec)]);

  p_masked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_valid && !en_q[raise_vec])
      |=> (!req_q[$past(raise_vec)] || $past(req_q[raise_vec])));

  p_pend_is_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> ((req_q >> pend_vec) == ONE_V));

  p_pend_above_svc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> ((svc_q >> pend_vec) == '0));

  p_ack_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (svc_q[$past(ack_vec)] && !req_q[$past(ack_vec)]));

  p_eoi_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !ack_valid && svc_q != '0)
      |=> ($countones(svc_q) + 1 == $countones($past(svc_q))));

  p_spurious_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && svc_q == '0) |=> spurious_eoi);

  p_spurious_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spurious_eoi |-> $past(eoi_valid));
endmodule

bind vit_tracker vit_tracker_chk #(.NUM_VEC(NUM_VEC)) i_vit_chk (
  .clk(clk), .rst_n(rst_n),
  .raise_valid(raise_valid), .raise_vec(raise_vec),
  .ack_valid(ack_valid), .ack_vec(ack_vec),
  .eoi_valid(eoi_valid),
  .pend_valid(pend_valid), .pend_vec(pend_vec), .spurious_eoi(spurious_eoi),
  .req_q(req_q), .svc_q(svc_q), .en_q(en_q)
);

// File: tb/test_vit_tracker.sv
`timescale 1ns/10ps
module test_vit_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        raise_valid, ack_valid, eoi_valid, en_wr_valid;
  logic [7:0]  raise_vec, ack_vec;
  logic [2:0]  en_wr_idx, rd_idx;
  logic [31:0] en_wr_data, rd_data;
  logic [1:0]  rd_sel;
  logic        pend_valid, spurious_eoi;
  logic [7:0]  pend_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [255:0] m_req, m_svc, m_en;
  logic [31:0]  lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  vit_tracker i_vit_tracker (
    .clk(clk), .rst_n(rst_n),
    .raise_valid(raise_valid), .raise_vec(raise_vec),
    .ack_valid(ack_valid), .ack_vec(ack_vec),
    .eoi_valid(eoi_valid),
    .en_wr_valid(en_wr_valid), .en_wr_idx(en_wr_idx), .en_wr_data(en_wr_data),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .pend_valid(pend_valid), .pend_vec(pend_vec), .spurious_eoi(spurious_eoi)
  );

  function automatic int top_bit(input logic [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare outputs and every slice of every array with the model.
  task automatic compare_all(input string tag, input bit spur_exp);
    int hr, hs;
    bit pe;
    logic [31:0] ex;
    hr = top_bit(m_req);
    hs = top_bit(m_svc);
    pe = (hr >= 0) && (hr > hs);
    check(pend_valid == pe, tag, "pend_valid", 32'(pend_valid), 32'(pe));
    check(pend_vec == (pe ? 8'(hr) : 8'd0), tag, "pend_vec", 32'(pend_vec), pe ? 32'(hr) : 32'd0);
    check(spurious_eoi == spur_exp, tag, "spurious_eoi", 32'(spurious_eoi), 32'(spur_exp));
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 8; k++) begin
        rd_sel = 2'(s);
        rd_idx = 3'(k);
        #0.05;
        case (s)
          0: ex = m_req[k*32 +: 32];
          1: ex = m_svc[k*32 +: 32];
          2: ex = m_en[k*32 +: 32];
          default: ex = 32'd0;
        endcase
        check(rd_data == ex, tag, $sformatf("slice sel%0d idx%0d", s, k), rd_data, ex);
      end
    end
  endtask

  task automatic do_cyc(input bit rv_v, input int rv, input bit ak_v, input int ak,
                        input bit eo, input bit ew_v, input int ew_i,
                        input logic [31:0] ew_d, input string tag);
    int vic;
    bit sp;
    raise_valid = rv_v; raise_vec = 8'(rv);
    ack_valid = ak_v;   ack_vec = 8'(ak);
    eoi_valid = eo;
    en_wr_valid = ew_v; en_wr_idx = 3'(ew_i); en_wr_data = ew_d;
    vic = top_bit(m_svc);
    sp = eo && (vic < 0);
    if (rv_v && m_en[rv]) m_req[rv] = 1'b1;
    if (ak_v) m_req[ak] = 1'b0;
    if (eo && vic >= 0) m_svc[vic] = 1'b0;
    if (ak_v) m_svc[ak] = 1'b1;
    if (ew_v) m_en[ew_i*32 +: 32] = ew_d;
    @(posedge clk); #1;
    raise_valid = 0; ack_valid = 0; eoi_valid = 0; en_wr_valid = 0;
    compare_all(tag, sp);
  endtask

  task automatic idle(input string tag);
    do_cyc(0, 0, 0, 0, 0, 0, 0, 32'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    raise_valid = 0; ack_valid = 0; eoi_valid = 0; en_wr_valid = 0;
    raise_vec = 0; ack_vec = 0; en_wr_idx = 0; en_wr_data = 0; rd_sel = 0; rd_idx = 0;
    m_req = '0; m_svc = '0; m_en = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    compare_all("R1", 0);
    idle("R1");

    // Exhaustive sweep of every vector through raise, ack, eoi
    for (int v = 0; v < 256; v++) begin
      do_cyc(1, v, 0, 0, 0, 0, 0, 32'd0, "R2");
      do_cyc(0, 0, 1, v, 0, 0, 0, 32'd0, "R6");
      do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R7");
    end

    // Nesting and strict priority
    do_cyc(1, 40, 0, 0, 0, 0, 0, 32'd0, "R2");
    do_cyc(0, 0, 1, 40, 0, 0, 0, 32'd0, "R6");
    do_cyc(1, 30, 0, 0, 0, 0, 0, 32'd0, "R5");
    do_cyc(1, 40, 0, 0, 0, 0, 0, 32'd0, "R5");
    do_cyc(1, 100, 0, 0, 0, 0, 0, 32'd0, "R4");
    do_cyc(0, 0, 1, 100, 0, 0, 0, 32'd0, "R6");
    do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R7");
    do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R7");
    do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R8");
    idle("R8");
    do_cyc(0, 0, 1, 40, 0, 0, 0, 32'd0, "R6");
    do_cyc(0, 0, 1, 30, 0, 0, 0, 32'd0, "R6");
    do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R7");
    do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R7");

    // Masking through enable slice writes
    do_cyc(0, 0, 0, 0, 0, 1, 1, 32'h0000_0000, "R9");
    do_cyc(1, 40, 0, 0, 0, 0, 0, 32'd0, "R3");
    do_cyc(1, 63, 0, 0, 0, 0, 0, 32'd0, "R3");
    do_cyc(1, 41, 0, 0, 0, 1, 1, 32'h0000_0200, "R10");
    do_cyc(1, 41, 0, 0, 0, 0, 0, 32'd0, "R2");
    do_cyc(1, 40, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, "R9");
    do_cyc(0, 0, 1, 41, 0, 0, 0, 32'd0, "R6");
    do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R7");

    // Same-cycle collisions
    do_cyc(1, 70, 0, 0, 0, 0, 0, 32'd0, "R10");
    do_cyc(0, 0, 1, 70, 0, 0, 0, 32'd0, "R10");
    do_cyc(1, 20, 0, 0, 1, 0, 0, 32'd0, "R10");
    do_cyc(0, 0, 1, 20, 1, 0, 0, 32'd0, "R10");
    do_cyc(1, 90, 1, 90, 0, 0, 0, 32'd0, "R10");
    do_cyc(0, 0, 1, 80, 1, 0, 0, 32'd0, "R10");
    do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R7");
    do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R7");
    do_cyc(0, 0, 0, 0, 1, 0, 0, 32'd0, "R8");

    // Mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      do_cyc(lfsr[0], int'(lfsr[15:8]), lfsr[1] & lfsr[2], int'(lfsr[23:16]),
             lfsr[3] & lfsr[4], lfsr[5] & lfsr[6] & lfsr[7], int'(lfsr[26:24]),
             {lfsr[15:0], lfsr[31:16]} | 32'hF0F0_0F0F, "R11");
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule